// File: doc/BRIEF.md
# Link-Event Reset Sequencer

This block turns link-layer exit events of a serial-link interface core into synchronous reset pulses. It drives two active-high reset outputs: a datapath reset for the core's protocol state machines and a configuration reset for the non-sticky configuration registers. Each exit event arrives as a one-cycle active-low pulse: leaving the link-up state, leaving hot reset, or leaving the L2 low-power state. Each reset pulse is stretched to a minimum length that a parameter sets. A static strap selects the port role. In endpoint mode every event resets both domains. In root-port mode a link-up exit resets only the datapath, so configuration state stays intact.

The block also forms the sticky-domain reset. This is the OR of an internal power-on request and the external PERST request. It is the only signal that resets sticky state, and no link event drives it. While it is active, both synchronous resets are held on. When it is removed, they are released through the same hold counter that link events use.

A status field records the cause of the most recent reset. Each bit of that field can be cleared by writing a one to it.

Top module: `lnk_rst_seq`

## Requirements
- R1: `sticky_rst_o` equals `por_req_i OR perst_req_i` at all times, and no link-exit input affects it.
- R2: At every rising edge where `sticky_rst_o` is high, the edge sets `srst_o` = 1, `crst_o` = 1 and `cause_o` = 4'b1000. Any link event or clear request on that same edge is overridden. After the last such edge, both resets stay high for HOLD-1 further edges and then fall.
- R3: With `role_rp_i` = 0 (endpoint), a low level on any of `lup_exit_n_i`, `hot_exit_n_i` or `l2_exit_n_i` at a rising edge makes both `srst_o` and `crst_o` high after that edge.
- R4: With `role_rp_i` = 1 (root port), a link-up exit alone makes `srst_o` high after the edge. It does not assert `crst_o` when `crst_o` was low.
- R5: With `role_rp_i` = 1, a hot-reset exit or an L2 exit makes both `srst_o` and `crst_o` high after the edge.
- R6: HOLD is 2 when `HARD_IMPL` = 1 and 1 when `HARD_IMPL` = 0, plus `EXTRA_CYC`. Suppose an event at edge k is followed by no further event. Then `srst_o` is high after edges k through k+HOLD-1 and low after edge k+HOLD.
- R7: An event that arrives while a pulse is running restarts the hold. The resets then fall HOLD edges after the latest event.
- R8: `crst_o` is never high while `srst_o` is low. Once `crst_o` is asserted, it falls on the same edge as `srst_o`, even if a root-port link-up exit retriggers the pulse.
- R9: At an edge with link events and no power-on request, `cause_o` is replaced by the set of events seen at that edge. The bit map is [0] link-up exit, [1] hot-reset exit, [2] L2 exit, [3] power-on.
- R10: At an edge with no event, each bit of `cause_clr_i` that is 1 clears the matching `cause_o` bit, and the other bits hold. At an edge with an event, the event's replacement wins over any clear request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock; all outputs except `sticky_rst_o` change on its rising edge |
| por_req_i | input | 1 | Internal power-on reset request, active high |
| perst_req_i | input | 1 | External PERST reset request, active high |
| role_rp_i | input | 1 | Static role strap: 0 endpoint, 1 root port |
| lup_exit_n_i | input | 1 | Link-up exit pulse, active low, one cycle |
| hot_exit_n_i | input | 1 | Hot-reset exit pulse, active low, one cycle |
| l2_exit_n_i | input | 1 | L2 low-power exit pulse, active low, one cycle |
| cause_clr_i | input | 4 | Write-one-to-clear strobes for `cause_o` bits |
| sticky_rst_o | output | 1 | Sticky-domain reset, OR of the two requests |
| srst_o | output | 1 | Synchronous datapath reset, active high |
| crst_o | output | 1 | Synchronous configuration reset, active high |
| cause_o | output | 4 | Cause of the most recent reset |

## Verification
The bench goes after retriggering. A second event one or two cycles into a pulse must extend it. A design that ignored the restart would release the resets one pulse length after the first event, which is too early. The root-port case of a hot-reset exit followed at once by a link-up exit is also checked. A design that recomputed `crst_o` per event would drop the configuration reset before the datapath reset.

Other corners follow:
- A clear and an event on the same edge, where wrongly losing the event would leave the cause empty.
- Simultaneous events, where only one bit might be recorded.
- Link events and clears while a power-on request is active, where they must not displace the power-on cause.
- The tail after the power-on request is released, where an off-by-one hold count would show.

// File: rtl/lnk_rst_pkg.sv
package lnk_rst_pkg;

    // Port role strap encoding
    typedef enum logic {
        ROLE_EP = 1'b0,
        ROLE_RP = 1'b1
    } port_role_e;

    // Event vector; bit order matches the cause field seen at the ports
    typedef struct packed {
        logic por;   // [3] power-on / PERST
        logic l2x;   // [2] L2 low-power exit
        logic hotx;  // [1] hot-reset exit
        logic lupx;  // [0] link-up exit
    } lnk_evt_t;

    localparam int unsigned CAUSE_W = $bits(lnk_evt_t);

    localparam lnk_evt_t EVT_NONE = '{por: 1'b0, l2x: 1'b0, hotx: 1'b0, lupx: 1'b0};
    localparam lnk_evt_t EVT_POR  = '{por: 1'b1, l2x: 1'b0, hotx: 1'b0, lupx: 1'b0};

    // Which reset domains an event asks for
    typedef struct packed {
        logic dp;    // datapath (srst)
        logic cfg;   // non-sticky configuration (crst)
    } rst_req_t;

    // Minimum pulse length in clock cycles
    function automatic int unsigned hold_len(input bit hard, input int unsigned extra);
        return (hard ? 2 : 1) + extra;
    endfunction

    function automatic logic evt_any(input lnk_evt_t e);
        return |e;
    endfunction

    // Root port keeps configuration across a plain link-up exit
    function automatic logic evt_hits_cfg(input lnk_evt_t e, input port_role_e r);
        return e.por | e.l2x | e.hotx | (e.lupx & (r == ROLE_EP));
    endfunction

endpackage

// File: rtl/lnk_rst_evt.sv
module lnk_rst_evt
    import lnk_rst_pkg::*;
(
    input  logic       por_req_i,
    input  logic       perst_req_i,
    input  port_role_e role_i,
    input  logic       lup_exit_n_i,
    input  logic       hot_exit_n_i,
    input  logic       l2_exit_n_i,
    output logic       sticky_rst_o,
    output lnk_evt_t   evt_o,
    output rst_req_t   req_o
);

    logic     sticky;
    lnk_evt_t evt;

    assign sticky = por_req_i | perst_req_i;

    always_comb begin
        evt      = EVT_NONE;
        evt.por  = sticky;
        evt.l2x  = ~l2_exit_n_i;
        evt.hotx = ~hot_exit_n_i;
        evt.lupx = ~lup_exit_n_i;
    end

    always_comb begin
        req_o.dp  = evt_any(evt);
        req_o.cfg = evt_hits_cfg(evt, role_i);
    end

    assign sticky_rst_o = sticky;
    assign evt_o        = evt;

endmodule

// File: rtl/lnk_rst_hold.sv
module lnk_rst_hold
    import lnk_rst_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 2
) (
    input  logic     clk_i,
    input  rst_req_t req_i,
    output logic     srst_o,
    output logic     crst_o
);

    logic srst_q;
    logic crst_q;

    generate
        if (HOLD_CYC <= 1) begin : g_single
            // One-cycle minimum: the pulse simply follows the request
            always_ff @(posedge clk_i) begin
                srst_q <= req_i.dp;
                crst_q <= req_i.cfg | (crst_q & req_i.dp);
            end
        end else begin : g_count
            localparam int unsigned CNT_W = $clog2(HOLD_CYC);
            localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC - 1);

            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk_i) begin
                if (req_i.dp) begin
                    srst_q <= 1'b1;
                    crst_q <= req_i.cfg | crst_q;
                    cnt_q  <= CNT_LOAD;
                end else if (cnt_q != '0) begin
                    cnt_q  <= cnt_q - 1'b1;
                end else begin
                    srst_q <= 1'b0;
                    crst_q <= 1'b0;
                end
            end
        end
    endgenerate

    assign srst_o = srst_q;
    assign crst_o = crst_q;

endmodule

// File: rtl/lnk_rst_cause.sv
module lnk_rst_cause
    import lnk_rst_pkg::*;
(
    input  logic               clk_i,
    input  lnk_evt_t           evt_i,
    input  logic [CAUSE_W-1:0] clr_i,
    output logic [CAUSE_W-1:0] cause_o
);

    lnk_evt_t cause_q;

    always_ff @(posedge clk_i) begin
        if (evt_i.por) begin
            cause_q <= EVT_POR;
        end else if (evt_any(evt_i)) begin
            cause_q <= evt_i;
        end else begin
            cause_q <= lnk_evt_t'(cause_q & ~clr_i);
        end
    end

    assign cause_o = cause_q;

endmodule

// File: rtl/lnk_rst_seq.sv
module lnk_rst_seq
    import lnk_rst_pkg::*;
#(
    parameter bit          HARD_IMPL = 1'b1,
    parameter int unsigned EXTRA_CYC = 0
) (
    input  logic               clk_i,
    input  logic               por_req_i,
    input  logic               perst_req_i,
    input  logic               role_rp_i,
    input  logic               lup_exit_n_i,
    input  logic               hot_exit_n_i,
    input  logic               l2_exit_n_i,
    input  logic [CAUSE_W-1:0] cause_clr_i,
    output logic               sticky_rst_o,
    output logic               srst_o,
    output logic               crst_o,
    output logic [CAUSE_W-1:0] cause_o
);

    localparam int unsigned HOLD_CYC = hold_len(HARD_IMPL, EXTRA_CYC);

    lnk_evt_t evt;
    rst_req_t req;

    lnk_rst_evt u_evt (
        .por_req_i    (por_req_i),
        .perst_req_i  (perst_req_i),
        .role_i       (port_role_e'(role_rp_i)),
        .lup_exit_n_i (lup_exit_n_i),
        .hot_exit_n_i (hot_exit_n_i),
        .l2_exit_n_i  (l2_exit_n_i),
        .sticky_rst_o (sticky_rst_o),
        .evt_o        (evt),
        .req_o        (req)
    );

    lnk_rst_hold #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk_i  (clk_i),
        .req_i  (req),
        .srst_o (srst_o),
        .crst_o (crst_o)
    );

    lnk_rst_cause u_cause (
        .clk_i   (clk_i),
        .evt_i   (evt),
        .clr_i   (cause_clr_i),
        .cause_o (cause_o)
    );

endmodule

// File: rtl/lnk_rst_seq_chk.sv
module lnk_rst_seq_chk #(
    parameter int unsigned HOLD_CYC = 2
) (
    input logic       clk_i,
    input logic       role_rp_i,
    input logic       lup_exit_n_i,
    input logic       hot_exit_n_i,
    input logic       l2_exit_n_i,
    input logic [3:0] cause_clr_i,
    input logic       sticky_rst_o,
    input logic       srst_o,
    input logic       crst_o,
    input logic [3:0] cause_o
);

    logic [2:0] lev;
    logic       no_ev;

    assign lev   = {~l2_exit_n_i, ~hot_exit_n_i, ~lup_exit_n_i};
    assign no_ev = (lev == 3'b000) && !sticky_rst_o;

    // R2: the sticky request is itself the reset here, so this property has no disable
    assert_por_hold_R2: assert property (@(posedge clk_i)
        sticky_rst_o |=> (srst_o && crst_o && cause_o == 4'b1000));

    assert_ep_both_R3: assert property (@(posedge clk_i) disable iff (sticky_rst_o)
        (!role_rp_i && lev != 3'b000) |=> (srst_o && crst_o));

    assert_rp_lup_only_R4: assert property (@(posedge clk_i) disable iff (sticky_rst_o)
        (role_rp_i && lev == 3'b001 && !crst_o) |=> (srst_o && !crst_o));

    assert_rp_other_R5: assert property (@(posedge clk_i) disable iff (sticky_rst_o)
        (role_rp_i && (lev[1] || lev[2])) |=> (srst_o && crst_o));

    generate
        if (HOLD_CYC >= 2) begin : g_min
            assert_min_len_R6: assert property (@(posedge clk_i) disable iff (sticky_rst_o)
                ($rose(srst_o) && no_ev) |=> srst_o);
        end
    endgenerate

    assert_fall_after_quiet_R7: assert property (@(posedge clk_i) disable iff (sticky_rst_o)
        $fell(srst_o) |-> $past(no_ev));

    assert_crst_in_srst_R8: assert property (@(posedge clk_i) disable iff (sticky_rst_o)
        crst_o |-> srst_o);

    assert_cause_latest_R9: assert property (@(posedge clk_i) disable iff (sticky_rst_o)
        (lev != 3'b000) |=> (cause_o == {1'b0, $past(lev)}));

    assert_w1c_R10: assert property (@(posedge clk_i) disable iff (sticky_rst_o)
        (no_ev && cause_clr_i != 4'b0000) |=> ((cause_o & $past(cause_clr_i)) == 4'b0000));

endmodule

bind lnk_rst_seq lnk_rst_seq_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk_i        (clk_i),
    .role_rp_i    (role_rp_i),
    .lup_exit_n_i (lup_exit_n_i),
    .hot_exit_n_i (hot_exit_n_i),
    .l2_exit_n_i  (l2_exit_n_i),
    .cause_clr_i  (cause_clr_i),
    .sticky_rst_o (sticky_rst_o),
    .srst_o       (srst_o),
    .crst_o       (crst_o),
    .cause_o      (cause_o)
);

// File: tb/lnk_rst_seq_tb.sv
module lnk_rst_seq_tb;

    localparam int HOLD = 2;  // default parameters: hard setting, no extra cycles

    logic       clk = 1'b0;
    logic       por_req, perst_req, role_rp;
    logic       lup_n, hot_n, l2_n;
    logic [3:0] clr;
    logic       sticky, srst, crst;
    logic [3:0] cause;

    always #4 clk = ~clk;  // 125 MHz

    lnk_rst_seq u_dut (
        .clk_i        (clk),
        .por_req_i    (por_req),
        .perst_req_i  (perst_req),
        .role_rp_i    (role_rp),
        .lup_exit_n_i (lup_n),
        .hot_exit_n_i (hot_n),
        .l2_exit_n_i  (l2_n),
        .cause_clr_i  (clr),
        .sticky_rst_o (sticky),
        .srst_o       (srst),
        .crst_o       (crst),
        .cause_o      (cause)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string tag   = "R2";

    // Behavioural reference: deadline edge for release, flag for config reset
    int       cyc     = 0;
    int       rel_at  = 0;
    bit       cfg_on  = 1'b0;
    bit       armed   = 1'b0;
    bit       exp_s   = 1'b0;
    bit       exp_c   = 1'b0;
    logic [3:0] exp_cause = 4'b0000;

    always @(posedge clk) begin
        logic       p;
        logic [3:0] evb;
        cyc = cyc + 1;
        p   = por_req | perst_req;
        evb = {p, ~l2_n, ~hot_n, ~lup_n};
        if (evb != 4'b0000) begin
            rel_at = cyc + HOLD;
            if (p || evb[2] || evb[1] || (evb[0] && !role_rp)) cfg_on = 1'b1;
        end
        exp_s = (cyc < rel_at);
        if (!exp_s) cfg_on = 1'b0;
        exp_c = cfg_on;
        if (p)                    exp_cause = 4'b1000;
        else if (evb != 4'b0000)  exp_cause = evb;
        else                      exp_cause = exp_cause & ~clr;
        if (p) armed = 1'b1;
    end

    task automatic chk(input string t, input string what, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h (t=%0t)", t, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (armed) begin
            chk(tag,  "srst",   {3'b000, srst},   {3'b000, exp_s});
            chk(tag,  "crst",   {3'b000, crst},   {3'b000, exp_c});
            chk(tag,  "cause",  cause,            exp_cause);
            chk("R1", "sticky", {3'b000, sticky}, {3'b000, por_req | perst_req});
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic ev(input bit lu, input bit ho, input bit l2v);
        lup_n = ~lu;
        hot_n = ~ho;
        l2_n  = ~l2v;
        step();
        lup_n = 1'b1;
        hot_n = 1'b1;
        l2_n  = 1'b1;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        por_req   = 1'b1;
        perst_req = 1'b0;
        role_rp   = 1'b0;
        lup_n     = 1'b1;
        hot_n     = 1'b1;
        l2_n      = 1'b1;
        clr       = 4'b0000;

        // R2: power-on hold and release tail
        tag = "R2";
        idle(3);
        por_req = 1'b0;
        idle(4);

        // R1: PERST alone drives the sticky reset
        tag = "R1";
        perst_req = 1'b1;
        idle(2);
        perst_req = 1'b0;
        idle(4);

        // R3: endpoint, each event kind
        tag = "R3";
        ev(1, 0, 0); idle(3);
        ev(0, 1, 0); idle(3);
        ev(0, 0, 1); idle(3);

        // R6: exact pulse length
        tag = "R6";
        ev(1, 0, 0); idle(4);

        // R10: write-one clear, clear of an unset bit, clear against an event
        tag = "R10";
        clr = 4'b0001; step();
        clr = 4'b0100; step();
        clr = 4'b0010;
        ev(0, 1, 0);
        clr = 4'b0000;
        idle(3);

        // R4: root port link-up exit keeps configuration
        tag = "R4";
        role_rp = 1'b1;
        ev(1, 0, 0); idle(3);

        // R5: root port hot-reset and L2 exits reset both
        tag = "R5";
        ev(0, 1, 0); idle(3);
        ev(0, 0, 1); idle(3);

        // R7: retrigger in both roles
        tag = "R7";
        ev(0, 1, 0); ev(1, 0, 0); idle(4);
        role_rp = 1'b0;
        ev(1, 0, 0); idle(1); ev(1, 0, 0); idle(4);

        // R8: crst held to the common release after a root-port link-up retrigger
        tag = "R8";
        role_rp = 1'b1;
        ev(0, 0, 1); step(); ev(1, 0, 0); idle(4);

        // R9: simultaneous events recorded together
        tag = "R9";
        ev(0, 1, 1); idle(3);
        ev(1, 1, 1); idle(3);

        // R2: link events and clears under power-on do not displace its cause
        tag = "R2";
        por_req = 1'b1;
        ev(1, 0, 0);
        clr = 4'b1111; step();
        clr = 4'b0000;
        por_req = 1'b0;
        idle(4);

        finish_run();
    end

endmodule